// File: doc/BRIEF.md
# Bidirectional Turbine Flow and Volume Meter

This block sits behind two optical sensors that watch a spinning vane. Each sensor gives a square wave, already cleaned up by a Schmitt trigger. The two waves are a quarter cycle apart, and which one leads tells the direction of the airflow. Each beam is broken twice per revolution of the vane. The block resynchronises both channels and filters out short glitches. It then follows the two-bit Gray state of the pair and keeps a signed step count, which is a measure of the volume that has passed.

On every accepted rising edge of channel A, the block also captures the number of clock cycles since the previous rising edge. Flow is a constant divided by this period, and that division is left to the host. If channel A stays quiet for longer than a programmable limit, the period is forced to all ones and a stall flag is raised, which means zero flow. A clear strobe from the host zeroes the volume count and the sequence-error flag.

Top module: `qflow_meter`

## Requirements
- R1: Each sensor input passes through two synchronising flops and then a filter. A new level is accepted only after it has been held for FILT_LEN consecutive cycles, so a pulse shorter than FILT_LEN cycles leaves the volume unchanged.
- R2: With the filtered state written as {A,B}, the forward order is 00, 01, 11, 10, 00. Each forward step adds one to `volume`.
- R3: Each step in the opposite order (00, 10, 11, 01, 00) subtracts one from `volume`.
- R4: A change of both bits at once sets `seq_err` and leaves `volume` unchanged.
- R5: `dir_rev` is 1 after a reverse step and 0 after a forward step. An illegal jump leaves it unchanged.
- R6: A level change on a sensor pin shows on `volume`, `dir_rev` and `seq_err` at the (3+FILT_LEN)-th rising clock edge after the change, and not before that edge.
- R7: `period` is the number of clock cycles between two successive accepted rising edges of A.
- R8: When no rising edge of A has been accepted for `stall_limit` cycles, `stall` goes to 1 and `period` becomes all ones.
- R9: The first rising edge of A after a stall clears `stall` and keeps `period` at all ones. The next edge gives a real period.
- R10: A one-cycle `clr` sets `volume` to 0 and clears `seq_err`, and it wins over a step in the same cycle. `clr` does not change `period` or `stall`.
- R11: After reset, `volume` is 0, `dir_rev` is 0, `seq_err` is 0, `stall` is 1 and `period` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Host strobe that zeroes the volume count and the error flag |
| sens_a | input | 1 | Sensor channel A, asynchronous |
| sens_b | input | 1 | Sensor channel B, asynchronous |
| stall_limit | input | PW | Number of idle cycles after which a stall is declared |
| volume | output | VW | Signed step count |
| dir_rev | output | 1 | Direction of the last legal step, 1 = reverse |
| seq_err | output | 1 | Sticky flag for an illegal double-bit jump |
| period | output | PW | Cycles between the last two rising edges of A |
| stall | output | 1 | No rising edge of A within the limit |

## Verification
A sensor edge reaches `volume`, `dir_rev` and `seq_err` at the (3+FILT_LEN)-th clock edge after it. The period and stall outputs follow the accepted rising edge of A in the same cycle that the count moves.

Outside the dedicated latency test, every stimulus is held for ten cycles before the outputs are sampled on a falling clock edge, so the results have settled by the time they are read. The latency test samples one falling edge before the due edge and one after it. The period test changes the inputs at a fixed spacing so that the filter delay cancels out of the measured interval.

// File: rtl/qflow_pkg.sv
package qflow_pkg;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_FWD  = 2'd1,
    STEP_REV  = 2'd2,
    STEP_BAD  = 2'd3
  } step_e;

  // Successor of a Gray state in the forward direction: 00 -> 01 -> 11 -> 10 -> 00
  function automatic logic [1:0] gray_fwd_next(input logic [1:0] s);
    case (s)
      2'b00:   gray_fwd_next = 2'b01;
      2'b01:   gray_fwd_next = 2'b11;
      2'b11:   gray_fwd_next = 2'b10;
      default: gray_fwd_next = 2'b00;
    endcase
  endfunction

  function automatic step_e classify_step(input logic [1:0] prev, input logic [1:0] cur);
    if (prev == cur)                       classify_step = STEP_NONE;
    else if ((prev ^ cur) == 2'b11)        classify_step = STEP_BAD;
    else if (gray_fwd_next(prev) == cur)   classify_step = STEP_FWD;
    else                                   classify_step = STEP_REV;
  endfunction

  // Increment that sticks at the all-ones value
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] maxv);
    sat_inc = (v >= maxv) ? maxv : v + 32'd1;
  endfunction

endpackage

// File: rtl/qflow_deglitch.sv
module qflow_deglitch #(
  parameter int FILT_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic          sync1, sync2;
  logic [CW-1:0] hold_cnt;
  logic          differs;

  assign differs = (sync2 != dout);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
    end else begin
      sync1 <= din;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      dout     <= 1'b0;
    end else if (!differs) begin
      hold_cnt <= '0;
    end else if (hold_cnt == LAST) begin
      hold_cnt <= '0;
      dout     <= sync2;
    end else begin
      hold_cnt <= hold_cnt + 1'b1;
    end
  end

  // R1
  filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !differs |=> $stable(dout));

endmodule

// File: rtl/qflow_quad_step.sv
module qflow_quad_step
  import qflow_pkg::*;
#(
  parameter int VW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic [1:0]           ab,
  output logic signed [VW-1:0] volume,
  output logic                 dir_rev,
  output logic                 seq_err,
  output logic                 a_rise
);
  logic [1:0] ab_prev;
  step_e      step;
  logic       step_fwd, step_rev, step_bad;

  assign step     = classify_step(ab_prev, ab);
  assign step_fwd = (step == STEP_FWD);
  assign step_rev = (step == STEP_REV);
  assign step_bad = (step == STEP_BAD);
  assign a_rise   = ab[1] & ~ab_prev[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ab_prev <= 2'b00;
    else        ab_prev <= ab;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      volume  <= '0;
      seq_err <= 1'b0;
    end else if (clr) begin
      volume  <= '0;
      seq_err <= 1'b0;
    end else begin
      if (step_fwd)      volume <= volume + 1'b1;
      else if (step_rev) volume <= volume - 1'b1;
      if (step_bad)      seq_err <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dir_rev <= 1'b0;
    else if (step_fwd) dir_rev <= 1'b0;
    else if (step_rev) dir_rev <= 1'b1;
  end

  // R2
  fwd_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fwd && !clr) |=> volume == $past(volume) + 1'b1);
  // R3
  rev_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_rev && !clr) |=> volume == $past(volume) - 1'b1);
  // R4
  bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_bad && !clr) |=> ($stable(volume) && seq_err));
  // R5
  dir_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_fwd |=> !dir_rev);
  // R10
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (volume == '0 && !seq_err));

endmodule

// File: rtl/qflow_period_timer.sv
module qflow_period_timer
  import qflow_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_rise,
  input  logic [PW-1:0] stall_limit,
  output logic [PW-1:0] period,
  output logic          stall
);
  localparam logic [PW-1:0] PMAX = '1;

  logic [PW-1:0] idle_cnt;
  logic          idle_expired;

  assign idle_expired = !a_rise && (idle_cnt >= stall_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         idle_cnt <= '0;
    else if (a_rise)    idle_cnt <= '0;
    else                idle_cnt <= PW'(sat_inc(32'(idle_cnt), 32'(PMAX)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period <= PMAX;
      stall  <= 1'b1;
    end else if (a_rise) begin
      stall <= 1'b0;
      if (!stall) period <= PW'(sat_inc(32'(idle_cnt), 32'(PMAX)));
    end else if (idle_expired) begin
      stall  <= 1'b1;
      period <= PMAX;
    end
  end

  // R8
  stall_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> period == PMAX);
  // R9
  first_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rise && stall) |=> (!stall && period == PMAX));
  // R7
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_rise && !idle_expired) |=> $stable(period));

endmodule

// File: rtl/qflow_meter.sv
module qflow_meter #(
  parameter int FILT_LEN = 2,
  parameter int VW       = 16,
  parameter int PW       = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 sens_a,
  input  logic                 sens_b,
  input  logic [PW-1:0]        stall_limit,
  output logic signed [VW-1:0] volume,
  output logic                 dir_rev,
  output logic                 seq_err,
  output logic [PW-1:0]        period,
  output logic                 stall
);
  localparam int NCH = 2;

  logic [NCH-1:0] raw_in;
  logic [NCH-1:0] clean;
  logic           a_rise;

  assign raw_in = {sens_a, sens_b};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    qflow_deglitch #(.FILT_LEN(FILT_LEN)) u_flt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_in[ch]),
      .dout (clean[ch])
    );
  end

  qflow_quad_step #(.VW(VW)) u_step (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .ab     (clean),
    .volume (volume),
    .dir_rev(dir_rev),
    .seq_err(seq_err),
    .a_rise (a_rise)
  );

  qflow_period_timer #(.PW(PW)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .a_rise     (a_rise),
    .stall_limit(stall_limit),
    .period     (period),
    .stall      (stall)
  );

  // R10
  clr_keeps_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !a_rise && !stall && (period != '1)) |=> $stable(period));

endmodule

// File: tb/qflow_meter_test.sv
`timescale 1ns/1ps
module qflow_meter_test;
  localparam int FILT = 2;
  localparam int VW   = 16;
  localparam int PW   = 16;
  localparam int HOLD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic sens_a = 1'b0, sens_b = 1'b0;
  logic [PW-1:0] stall_limit = PW'(1000);
  logic signed [VW-1:0] volume;
  logic dir_rev, seq_err, stall;
  logic [PW-1:0] period;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  qflow_meter #(.FILT_LEN(FILT), .VW(VW), .PW(PW)) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .sens_a(sens_a), .sens_b(sens_b),
    .stall_limit(stall_limit), .volume(volume), .dir_rev(dir_rev),
    .seq_err(seq_err), .period(period), .stall(stall)
  );

  // Entry: {a, b, exp_dir, exp_err, exp_volume}
  localparam int NV = 9;
  localparam logic [19:0] TBL [NV] = '{
    {1'b0, 1'b1, 1'b0, 1'b0, 16'd1},
    {1'b1, 1'b1, 1'b0, 1'b0, 16'd2},
    {1'b1, 1'b0, 1'b0, 1'b0, 16'd3},
    {1'b0, 1'b0, 1'b0, 1'b0, 16'd4},
    {1'b0, 1'b1, 1'b0, 1'b0, 16'd5},
    {1'b0, 1'b0, 1'b1, 1'b0, 16'd4},
    {1'b1, 1'b0, 1'b1, 1'b0, 16'd3},
    {1'b1, 1'b1, 1'b1, 1'b0, 16'd2},
    {1'b0, 1'b0, 1'b1, 1'b1, 16'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic a, input logic b, input int hold);
    sens_a = a;
    sens_b = b;
    repeat (hold) @(negedge clk);
  endtask

  task automatic fwd_loop(input int ph);
    drive(1'b0, 1'b1, ph);
    drive(1'b1, 1'b1, ph);
    drive(1'b1, 1'b0, ph);
    drive(1'b0, 1'b0, ph);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [PW-1:0] p_keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 volume", 32'(volume), 32'd0);
    chk("R11 dir_rev", 32'(dir_rev), 32'd0);
    chk("R11 seq_err", 32'(seq_err), 32'd0);
    chk("R11 stall", 32'(stall), 32'd1);
    chk("R11 period", 32'(period), 32'hFFFF);

    // Table walk: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i][19], TBL[i][18], HOLD);
      if (TBL[i][16])      chk("R4 volume", 32'(volume), 32'(TBL[i][15:0]));
      else if (TBL[i][17]) chk("R3 volume", 32'(volume), 32'(TBL[i][15:0]));
      else                 chk("R2 volume", 32'(volume), 32'(TBL[i][15:0]));
      chk("R5 dir_rev", 32'(dir_rev), 32'(TBL[i][17]));
      chk("R4 seq_err", 32'(seq_err), 32'(TBL[i][16]));
    end

    // R10 clear
    p_keep = period;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    @(negedge clk);
    chk("R10 volume", 32'(volume), 32'd0);
    chk("R10 seq_err", 32'(seq_err), 32'd0);
    chk("R10 period", 32'(period), 32'(p_keep));

    // R6 latency: forward step 00 -> 01
    sens_b = 1'b1;
    repeat (2 + FILT) @(negedge clk);
    chk("R6 before due edge", 32'(volume), 32'd0);
    @(negedge clk);
    chk("R6 at due edge", 32'(volume), 32'd1);
    repeat (HOLD) @(negedge clk);
    drive(1'b0, 1'b0, HOLD);
    chk("R3 back to zero", 32'(volume), 32'd0);

    // R1 glitch shorter than the filter
    drive(1'b0, 1'b1, FILT - 1);
    drive(1'b0, 1'b0, HOLD);
    chk("R1 glitch volume", 32'(volume), 32'd0);
    chk("R1 glitch dir", 32'(dir_rev), 32'd1);

    // R7 period with A rising every 20 cycles
    for (int k = 0; k < 3; k++) fwd_loop(5);
    repeat (HOLD) @(negedge clk);
    chk("R7 period", 32'(period), 32'd20);
    chk("R7 no stall", 32'(stall), 32'd0);
    chk("R2 loops volume", 32'(volume), 32'd12);

    // R8 stall
    stall_limit = PW'(60);
    repeat (100) @(negedge clk);
    chk("R8 stall", 32'(stall), 32'd1);
    chk("R8 period", 32'(period), 32'hFFFF);

    // R9 first rise after stall
    fwd_loop(5);
    chk("R9 stall cleared", 32'(stall), 32'd0);
    chk("R9 period held", 32'(period), 32'hFFFF);
    fwd_loop(5);
    chk("R9 next period", 32'(period), 32'd20);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule